// File: doc/BRIEF.md
# Dual-Phase Frame Serial Transmitter

This block turns parallel words into a serial bit stream on one data pin. A frame carries either one phase or two, and each phase has its own word length and word count. A frame can therefore mix word sizes, for example a run of 12-bit words followed by a run of 32-bit words. Software writes each word into a single holding register. The block copies that word into a separate shift register when the word is due to start. A ready output tells the writer when the holding register can take the next word.

A bit-rate enable input paces the output: one data bit leaves per enable cycle. A frame starts in one of two ways. In external mode it starts on a sampled frame-sync input. In internal mode it starts as soon as a word is waiting, and the block drives its own frame-sync pulse each time it starts a word. If no fresh word is waiting when a word must start, the previous word goes out again and an underflow flag is raised. An interrupt pulse follows either the holding register emptying or the end of a frame, chosen by a mode input.

Top module: `dpf_serial_tx`

## Requirements
- R1: After reset, tx_data, fs_out, irq and underflow are 0 and ready is 1.
- R2: Words leave most significant bit first, one bit per cycle with bit_en high. The first bit is on tx_data in the cycle after the clock edge that started the frame. tx_data changes only at edges where bit_en was high.
- R3: Length codes select the word length: code 0 = 8 bits, 1 = 12, 2 = 16, 3 = 20, 4 = 24, 5 = 32. Codes 6 and 7 give 8 bits. Only the low bits of the written word, up to the word length, are sent.
- R4: A phase holds ph_words_m1 + 1 words, so a field value of 0 to 127 gives 1 to 128 words.
- R5: With two_phase = 1, phase 2 follows phase 1 inside the same frame and uses its own length code and count. With two_phase = 0, the phase-2 fields have no effect.
- R6: A write is taken only while ready = 1, and ready reads 0 from the next cycle. A write while ready = 0 is ignored.
- R7: ready returns to 1 in the cycle after the held word is copied into the shift register.
- R8: With fs_int_sel = 1, a frame starts at the first bit_en edge with a word held. fs_out is then a one-cycle pulse after every word start, and fs_ext_in is ignored. With fs_int_sel = 0, fs_out stays 0 and a frame starts at a bit_en edge with fs_ext_in = 1.
- R9: If the holding register is empty when a word must start, the previous word is sent again and underflow goes to 1. A later accepted write clears underflow.
- R10: With irq_mode = 0, irq pulses for one cycle each time ready returns to 1. With irq_mode = 1, irq pulses once after the last bit of each frame.
- R11: fs_ext_in is ignored while a frame is in progress. Between frames tx_data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable; one serial bit per high cycle |
| fs_int_sel | input | 1 | 1: internal frame start on a held word; 0: start on fs_ext_in |
| fs_ext_in | input | 1 | External frame sync, sampled on bit_en edges |
| two_phase | input | 1 | 1: frame has two phases |
| ph1_len_code | input | 3 | Phase-1 word length code |
| ph1_words_m1 | input | CNT_W | Phase-1 word count minus one |
| ph2_len_code | input | 3 | Phase-2 word length code |
| ph2_words_m1 | input | CNT_W | Phase-2 word count minus one |
| irq_mode | input | 1 | Interrupt source: 0 ready, 1 end of frame |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DATA_W | Word to hold |
| tx_data | output | 1 | Serial data |
| fs_out | output | 1 | Internally generated frame-sync pulse |
| ready | output | 1 | Holding register can accept a word |
| underflow | output | 1 | A word was repeated for lack of new data |
| irq | output | 1 | Interrupt pulse |

## Verification
Most internal faults show up directly on tx_data within one word. A stale bit counter or a wrong length decode shifts every following bit out of alignment. A wrong phase or word counter makes the frame end early or late, and then the idle level, the count of frame-sync pulses and the end-of-frame interrupt are wrong at the end of that frame. Holding-register faults show up on ready within one cycle of a write or a copy. A wrong word selection at underflow shows up in the repeated word and the underflow flag at the next word boundary.

// File: rtl/dpf_tx_pkg.sv
package dpf_tx_pkg;
   localparam int LEN_W  = 6;   // holds lengths up to 32
   localparam int CODE_W = 3;

   // R3: length code to bit count; reserved codes fall back to 8
   function automatic logic [LEN_W-1:0] code_to_len(input logic [CODE_W-1:0] code);
      logic [LEN_W-1:0] len;
      case (code)
         3'd0:    len = LEN_W'(8);
         3'd1:    len = LEN_W'(12);
         3'd2:    len = LEN_W'(16);
         3'd3:    len = LEN_W'(20);
         3'd4:    len = LEN_W'(24);
         3'd5:    len = LEN_W'(32);
         default: len = LEN_W'(8);
      endcase
      return len;
   endfunction
endpackage

// File: rtl/dpf_tx_hold.sv
module dpf_tx_hold #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   output logic [DATA_W-1:0] hold_data,
   output logic              full,
   output logic              accept
);
   logic              full_q;
   logic [DATA_W-1:0] data_q;

   assign accept    = wr_en & ~full_q;   // R6: writes while full are dropped
   assign full      = full_q;
   assign hold_data = data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         data_q <= '0;
      end else if (accept) begin
         full_q <= 1'b1;
         data_q <= wr_data;
      end else if (take) begin
         full_q <= 1'b0;
      end
   end
endmodule

// File: rtl/dpf_tx_seq.sv
module dpf_tx_seq #(
   parameter int CNT_W = 7,
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_en,
   input  logic             fs_int_sel,
   input  logic             fs_ext_in,
   input  logic             hold_full,
   input  logic             two_phase,
   input  logic [LEN_W-1:0] len1,
   input  logic [LEN_W-1:0] len2,
   input  logic [CNT_W-1:0] cnt1,
   input  logic [CNT_W-1:0] cnt2,
   output logic             active,
   output logic             load,
   output logic [LEN_W-1:0] load_len,
   output logic             shift_en,
   output logic             frame_end
);
   logic             active_q, active_d;
   logic             phase_q, phase_d;
   logic [CNT_W-1:0] word_q, word_d;
   logic [LEN_W-1:0] bit_q, bit_d;
   logic [LEN_W-1:0] cur_len;
   logic             start;

   assign cur_len = phase_q ? len2 : len1;
   // R8/R11: start source depends on mode; ignored while active
   assign start   = bit_en & (fs_int_sel ? hold_full : fs_ext_in);
   assign active  = active_q;

   always_comb begin
      active_d  = active_q;
      phase_d   = phase_q;
      word_d    = word_q;
      bit_d     = bit_q;
      load      = 1'b0;
      load_len  = len1;
      shift_en  = 1'b0;
      frame_end = 1'b0;
      if (!active_q) begin
         if (start) begin
            load     = 1'b1;
            load_len = len1;
            active_d = 1'b1;
            phase_d  = 1'b0;
            word_d   = cnt1;
            bit_d    = len1 - LEN_W'(1);
         end
      end else if (bit_en) begin
         if (bit_q != '0) begin
            shift_en = 1'b1;
            bit_d    = bit_q - LEN_W'(1);
         end else if (word_q != '0) begin
            load     = 1'b1;
            load_len = cur_len;
            word_d   = word_q - CNT_W'(1);
            bit_d    = cur_len - LEN_W'(1);
         end else if (!phase_q && two_phase) begin
            load     = 1'b1;
            load_len = len2;
            phase_d  = 1'b1;
            word_d   = cnt2;
            bit_d    = len2 - LEN_W'(1);
         end else begin
            active_d  = 1'b0;
            frame_end = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         phase_q  <= 1'b0;
         word_q   <= '0;
         bit_q    <= '0;
      end else begin
         active_q <= active_d;
         phase_q  <= phase_d;
         word_q   <= word_d;
         bit_q    <= bit_d;
      end
   end
endmodule

// File: rtl/dpf_tx_shifter.sv
module dpf_tx_shifter #(
   parameter int DATA_W    = 32,
   parameter int LEN_W     = 6,
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [LEN_W-1:0]  load_len,
   input  logic [DATA_W-1:0] load_word,
   input  logic              shift_en,
   output logic              ser_bit
);
   localparam int SH_W = $clog2(DATA_W) + 1;

   logic [DATA_W-1:0] shift_q;

   generate
      if (LSB_FIRST) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        shift_q <= '0;
            else if (load)     shift_q <= load_word;
            else if (shift_en) shift_q <= shift_q >> 1;
         end
         assign ser_bit = shift_q[0];
      end else begin : g_msb
         logic [SH_W-1:0] sh_amt;
         assign sh_amt = SH_W'(DATA_W) - SH_W'(load_len);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        shift_q <= '0;
            else if (load)     shift_q <= load_word << sh_amt;
            else if (shift_en) shift_q <= shift_q << 1;
         end
         assign ser_bit = shift_q[DATA_W-1];
      end
   endgenerate
endmodule

// File: rtl/dpf_serial_tx.sv
module dpf_serial_tx
   import dpf_tx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CNT_W     = 7,
   parameter bit LSB_FIRST = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_en,
   input  logic              fs_int_sel,
   input  logic              fs_ext_in,
   input  logic              two_phase,
   input  logic [2:0]        ph1_len_code,
   input  logic [CNT_W-1:0]  ph1_words_m1,
   input  logic [2:0]        ph2_len_code,
   input  logic [CNT_W-1:0]  ph2_words_m1,
   input  logic              irq_mode,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic              tx_data,
   output logic              fs_out,
   output logic              ready,
   output logic              underflow,
   output logic              irq
);
   generate
      if (DATA_W < 32) begin : g_bad_width
         $error("dpf_serial_tx: DATA_W must be at least 32");
      end
      if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
         $error("dpf_serial_tx: CNT_W out of range");
      end
   endgenerate

   logic [LEN_W-1:0]  len1, len2, load_len;
   logic [DATA_W-1:0] hold_data, load_word, last_q;
   logic              hold_full, accept;
   logic              active, load, shift_en, frame_end, ser_bit;
   logic              uf_q, fs_q, irq_q;

   assign len1 = code_to_len(ph1_len_code);
   assign len2 = code_to_len(ph2_len_code);

   dpf_tx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .take(load), .hold_data(hold_data), .full(hold_full), .accept(accept)
   );

   dpf_tx_seq #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fs_int_sel(fs_int_sel),
      .fs_ext_in(fs_ext_in), .hold_full(hold_full), .two_phase(two_phase),
      .len1(len1), .len2(len2), .cnt1(ph1_words_m1), .cnt2(ph2_words_m1),
      .active(active), .load(load), .load_len(load_len),
      .shift_en(shift_en), .frame_end(frame_end)
   );

   // R9: with nothing held, the previous word is reused
   assign load_word = hold_full ? hold_data : last_q;

   dpf_tx_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(load), .load_len(load_len),
      .load_word(load_word), .shift_en(shift_en), .ser_bit(ser_bit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= '0;
         uf_q   <= 1'b0;
         fs_q   <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         if (load) last_q <= load_word;
         if (load && !hold_full) uf_q <= 1'b1;
         else if (accept)        uf_q <= 1'b0;
         fs_q  <= load & fs_int_sel;
         irq_q <= irq_mode ? frame_end : (load & hold_full);
      end
   end

   assign tx_data   = active & ser_bit;
   assign fs_out    = fs_q;
   assign ready     = ~hold_full;
   assign underflow = uf_q;
   assign irq       = irq_q;
endmodule

// File: rtl/dpf_tx_chk.sv
module dpf_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_en,
   input logic fs_int_sel,
   input logic irq_mode,
   input logic wr_en,
   input logic tx_data,
   input logic fs_out,
   input logic ready,
   input logic underflow,
   input logic irq
);
   p_ready_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ready && wr_en |=> !ready);

   p_full_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !ready && !bit_en |=> !ready);

   p_tx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_en |=> $stable(tx_data));

   p_fs_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fs_out |=> !fs_out);

   p_fs_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !fs_int_sel && $past(!fs_int_sel) |-> !fs_out);

   p_irq_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_mode && $past(!irq_mode) && $rose(ready) |-> irq);

   p_irq_only_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_mode && $past(!irq_mode) && irq |-> ready);

   p_uf_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ready && wr_en && !bit_en |=> !underflow);
endmodule

bind dpf_serial_tx dpf_tx_chk u_chk (.*);

// File: tb/dpf_serial_tx_tb_top.sv
module dpf_serial_tx_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bit_en = 1'b0, fs_int_sel = 1'b0, fs_ext_in = 1'b0, two_phase = 1'b0;
   logic [2:0]  ph1_len_code = '0, ph2_len_code = '0;
   logic [6:0]  ph1_words_m1 = '0, ph2_words_m1 = '0;
   logic        irq_mode = 1'b0, wr_en = 1'b0;
   logic [31:0] wr_data = '0;
   logic        tx_data, fs_out, ready, underflow, irq;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] words [256];

   always #5 clk = ~clk;

   dpf_serial_tx dut_i (
      .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .fs_int_sel(fs_int_sel),
      .fs_ext_in(fs_ext_in), .two_phase(two_phase),
      .ph1_len_code(ph1_len_code), .ph1_words_m1(ph1_words_m1),
      .ph2_len_code(ph2_len_code), .ph2_words_m1(ph2_words_m1),
      .irq_mode(irq_mode), .wr_en(wr_en), .wr_data(wr_data),
      .tx_data(tx_data), .fs_out(fs_out), .ready(ready),
      .underflow(underflow), .irq(irq)
   );

   function automatic int exp_len(input logic [2:0] code);
      case (code)
         3'd1: return 12;
         3'd2: return 16;
         3'd3: return 20;
         3'd4: return 24;
         3'd5: return 32;
         default: return 8;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; bit_en = 0; wr_en = 0; fs_ext_in = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic run_frame(input bit ext, input bit two, input logic [2:0] c1, input int n1,
                            input logic [2:0] c2, input int n2, input int supplied,
                            input bit imode, input int dens, input bit dup, input bit xfs,
                            input string tag);
      bit exp_bits[$];
      int nwords, total, cap, errs, wi, fs_cnt, irq_cnt, guard, bad_i;
      bit started, start_pend, fs_done, dup_done, wrote_last, bad_a, bad_e;
      do_reset();
      nwords = n1 + (two ? n2 : 0);
      for (int i = 0; i < nwords; i++) words[i] = $urandom();
      for (int i = 0; i < nwords; i++) begin
         int len = (i < n1) ? exp_len(c1) : exp_len(c2);
         logic [31:0] w = (i < supplied) ? words[i] : words[supplied-1];
         for (int b = len - 1; b >= 0; b--) exp_bits.push_back(w[b]);
      end
      total = exp_bits.size();
      fs_int_sel = !ext; two_phase = two; irq_mode = imode;
      ph1_len_code = c1; ph1_words_m1 = 7'(n1 - 1);
      ph2_len_code = two ? c2 : 3'($urandom());
      ph2_words_m1 = two ? 7'(n2 - 1) : 7'($urandom());
      cap = 0; errs = 0; wi = 0; fs_cnt = 0; irq_cnt = 0; guard = 0; bad_i = 0;
      bad_a = 0; bad_e = 0;
      started = 0; start_pend = 0; fs_done = 0; dup_done = 0; wrote_last = 0;
      while (cap < total && guard < 20000) begin
         @(negedge clk);
         guard++;
         if (start_pend) begin
            started = 1; start_pend = 0;
            chk(ready == 1'b1, "R7", "ready after copy", ready, 1);
         end
         if (!ext && fs_out) started = 1;
         fs_cnt += int'(fs_out);
         irq_cnt += int'(irq);
         if (wrote_last && ext && !fs_done)
            chk(ready == 1'b0, "R6", "ready after write", ready, 0);
         bit_en = ($urandom() % 100) < dens;
         wr_en = 0; fs_ext_in = ext ? 1'b0 : 1'($urandom());
         if (started && bit_en && cap < total) begin
            if (tx_data !== exp_bits[cap] && errs == 0) begin
               bad_i = cap; bad_a = tx_data; bad_e = exp_bits[cap];
            end
            if (tx_data !== exp_bits[cap]) errs++;
            cap++;
         end
         wrote_last = 0;
         if (ready && wi < supplied) begin
            wr_en = 1; wr_data = words[wi]; wi++; wrote_last = 1;
         end else if (dup && !dup_done && wi == 1 && !ready) begin
            wr_en = 1; wr_data = ~words[0]; dup_done = 1;
         end else if (ext && !fs_done && wi >= 1 && !ready && (!dup || dup_done)) begin
            fs_ext_in = 1; bit_en = 1; fs_done = 1; start_pend = 1;
         end
         if (ext && xfs && started && cap == total / 2) fs_ext_in = 1;
      end
      chk(cap == total, "R2", {tag, " bits captured"}, cap, total);
      chk(errs == 0, tag, $sformatf("serial stream bit %0d", bad_i), bad_a, bad_e);
      wr_en = 0;
      repeat (40) begin
         @(negedge clk);
         fs_cnt += int'(fs_out);
         irq_cnt += int'(irq);
         bit_en = 1; fs_ext_in = 0;
      end
      chk(tx_data == 1'b0, "R11", "idle level after frame", tx_data, 0);
      chk(fs_cnt == (ext ? 0 : nwords), "R8", "fs_out pulse count", fs_cnt, ext ? 0 : nwords);
      chk(irq_cnt == (imode ? 1 : supplied), "R10", "irq pulse count", irq_cnt, imode ? 1 : supplied);
      chk(underflow == (supplied < nwords), "R9", "underflow flag", underflow, supplied < nwords);
      if (underflow) begin
         bit_en = 0; fs_int_sel = 0; wr_en = 1; wr_data = 32'h1;
         @(negedge clk);
         wr_en = 0;
         chk(underflow == 1'b0, "R9", "underflow cleared by write", underflow, 0);
      end
   endtask

   initial begin
      void'($urandom(32'h1d2c3b4a));
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset values
      chk({tx_data, fs_out, irq, underflow, ready} == 5'b00001, "R1", "reset outputs",
          {tx_data, fs_out, irq, underflow, ready}, 5'b00001);
      run_frame(1, 0, 3'd0, 1, 3'd0, 1, 1, 0, 100, 0, 0, "R2");
      for (int c = 0; c < 8; c++)
         run_frame(1, 0, 3'(c), 2, 3'd0, 1, 2, 0, 60, 0, 0, "R3");
      run_frame(0, 0, 3'd0, 128, 3'd0, 1, 128, 0, 100, 0, 0, "R4");
      run_frame(0, 1, 3'd1, 3, 3'd5, 2, 5, 1, 70, 0, 0, "R5");
      run_frame(1, 0, 3'd2, 1, 3'd5, 4, 1, 0, 80, 1, 0, "R6");
      run_frame(1, 1, 3'd0, 2, 3'd3, 2, 1, 0, 50, 0, 0, "R9");
      run_frame(0, 0, 3'd4, 3, 3'd0, 1, 2, 1, 100, 0, 0, "R9");
      run_frame(1, 1, 3'd5, 1, 3'd0, 3, 4, 1, 90, 0, 1, "R11");
      for (int k = 0; k < 16; k++) begin
         bit tw = 1'($urandom());
         int a = 1 + ($urandom() % 4), b = 1 + ($urandom() % 4);
         int nw = a + (tw ? b : 0);
         int sup = (($urandom() % 4) == 0) ? 1 + ($urandom() % nw) : nw;
         run_frame(1'($urandom()), tw, 3'($urandom()), a, 3'($urandom()), b, sup,
                   1'($urandom()), 30 + ($urandom() % 71), 0, 1'($urandom()), "R5");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule